// File: doc/BRIEF.md
# Write-Once Memory with Latched Address

This block models a synchronous one-time-programmable store of 8192 eight-bit words, kept as 256 rows by 256 columns. The columns form eight groups of 32, one group per data bit. The address is captured into an internal register on the clock edge at which the active-low chip select first reads low. After that edge the address pins are free, so the block can sit on a bus that carries address and data on the same wires.

Reads return the captured word one clock after capture. Chip select and output enable act independently. High impedance on the data pins is modelled as a drive-enable flag, and the data bus reads zero when it is not driven.

A write strobe (active low) ORs supplied ones into the selected word. Stored ones can never be cleared by a write. The array can only return to all zeros through a clearing sweep that runs after reset or after an initialise pulse.

Top module: `otp_prom`

## Requirements
- R1: Reset, or a one-cycle `init` pulse, starts a sweep. During the sweep `clr_busy` stays high for exactly 2^ADDR_W clock edges, and afterwards every word reads 0x00.
- R2: `addr` is captured on the rising clock edge at which `ce_n` is sampled low after being sampled high on the previous edge. It is held while `ce_n` stays low, and later changes on `addr` do not affect the access.
- R3: One edge after `ce_n` is sampled high, `drive_en` and `dvalid` are 0 and `rdata` is 0x00, whatever the value of `oe_n`.
- R4: When `ce_n` and `oe_n` are low, `dvalid` and `drive_en` go to 1 on the edge after capture, and `rdata` shows the stored word.
- R5: When `ce_n` is low and `oe_n` is high, `dvalid` is 1, `drive_en` is 0 and `rdata` is 0x00. Lowering `oe_n` then drives the same word one edge later, without a new capture.
- R6: A cycle with `pe_n` low, during a selected access after capture, stores old | `wdata` at the captured address. Bits that are already 1 are never cleared.
- R7: While `pe_n` is high, or while `ce_n` is high, `wdata` leaves the array unchanged.
- R8: `prog_done` is 1 for the cycle after each accepted programming cycle and 0 otherwise.
- R9: While `clr_busy` is high, reads are neither valid nor driven, and programming cycles are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, which also starts a clearing sweep |
| init | input | 1 | Synchronous request to clear the whole array |
| ce_n | input | 1 | Chip select, active low; the falling level latches the address |
| oe_n | input | 1 | Output enable, active low |
| pe_n | input | 1 | Programming strobe, active low |
| addr | input | 13 | Word address; bits [4:0] pick the column in each group and bits [12:5] pick the row |
| wdata | input | 8 | Ones to OR into the word |
| rdata | output | 8 | Read word; 0x00 when not driven |
| drive_en | output | 1 | Data pins driven |
| dvalid | output | 1 | Read data valid for the captured address |
| prog_done | output | 1 | Pulse one cycle after an accepted programming cycle |
| clr_busy | output | 1 | Clearing sweep in progress |

## Verification
The hardest state to reach from the ports is a word that has been programmed more than once, where a later pattern overlaps bits that are already set. The bench first programs every address with an arithmetic pattern. It then adds a second pattern to every third address and attempts ignored writes on every seventh. A full read sweep then compares each word with the OR of everything accepted there.

Access and programming attempts are also made while a clearing sweep is running. The array is then checked to return to zeros.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int OTP_DATA_W = 8;
  localparam int OTP_ROW_W  = 8;
  localparam int OTP_COL_W  = 5;
endpackage

// File: rtl/otp_addr_latch.sv
module otp_addr_latch #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              held,
  output logic [ADDR_W-1:0] lat_addr
);
  logic ce_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q     <= 1'b1;
      lat_addr <= '0;
    end else begin
      ce_q <= ce_n;
      if (!ce_n && ce_q) lat_addr <= addr;
    end
  end

  assign held = !ce_n && !ce_q;
endmodule

// File: rtl/otp_clear_seq.sv
module otp_clear_seq #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end else if (init) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end
endmodule

// File: rtl/otp_bit_plane.sv
module otp_bit_plane #(
  parameter int ROW_W = 8,
  parameter int COL_W = 5,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int ROWS   = 1 << ROW_W,
  localparam int COLS   = 1 << COL_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic [ADDR_W-1:0] raddr,
  output logic              q
);
  logic [COLS-1:0] cells [ROWS];

  logic [ROW_W-1:0] w_row, r_row;
  logic [COL_W-1:0] w_col, r_col;
  assign w_row = waddr[ADDR_W-1:COL_W];
  assign w_col = waddr[COL_W-1:0];
  assign r_row = raddr[ADDR_W-1:COL_W];
  assign r_col = raddr[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (we) cells[w_row][w_col] <= wbit;
    q <= cells[r_row][r_col];
  end
endmodule

// File: rtl/otp_prom.sv
module otp_prom
  import otp_pkg::*;
#(
  parameter int DATA_W = OTP_DATA_W,
  parameter int ROW_W  = OTP_ROW_W,
  parameter int COL_W  = OTP_COL_W,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              drive_en,
  output logic              dvalid,
  output logic              prog_done,
  output logic              clr_busy
);
  logic              held;
  logic [ADDR_W-1:0] lat_addr;
  logic [ADDR_W-1:0] clr_ptr;
  logic              fire;
  logic [DATA_W-1:0] plane_q;
  logic [ADDR_W-1:0] w_addr;

  otp_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst(rst), .ce_n(ce_n), .addr(addr),
    .held(held), .lat_addr(lat_addr)
  );

  otp_clear_seq #(.ADDR_W(ADDR_W)) u_clear (
    .clk(clk), .rst(rst), .init(init),
    .busy(clr_busy), .ptr(clr_ptr)
  );

  assign fire   = held && !pe_n && !clr_busy;
  assign w_addr = clr_busy ? clr_ptr : lat_addr;

  for (genvar b = 0; b < DATA_W; b++) begin : g_plane
    otp_bit_plane #(.ROW_W(ROW_W), .COL_W(COL_W)) u_plane (
      .clk(clk),
      .we(clr_busy || (fire && wdata[b])),
      .waddr(w_addr),
      .wbit(!clr_busy),
      .raddr(lat_addr),
      .q(plane_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvalid    <= 1'b0;
      drive_en  <= 1'b0;
      prog_done <= 1'b0;
    end else begin
      dvalid    <= held && !clr_busy;
      drive_en  <= held && !clr_busy && !oe_n;
      prog_done <= fire;
    end
  end

  assign rdata = drive_en ? plane_q : '0;
endmodule

// File: rtl/otp_prom_chk.sv
module otp_prom_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pe_n,
  input logic              drive_en,
  input logic              dvalid,
  input logic              prog_done,
  input logic              clr_busy,
  input logic [ADDR_W-1:0] lat_addr
);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !$past(ce_n) && !$past(ce_n, 2)) |-> $stable(lat_addr));
  // R3
  deselect_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!drive_en && !dvalid));
  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !drive_en);
  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> $past(!ce_n));
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> $past(!pe_n && !ce_n));
  // R9
  sweep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    clr_busy |=> (!drive_en && !prog_done));
endmodule

bind otp_prom otp_prom_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pe_n(pe_n),
  .drive_en(drive_en), .dvalid(dvalid), .prog_done(prog_done),
  .clr_busy(clr_busy), .lat_addr(lat_addr)
);

// File: tb/otp_prom_bench.sv
`timescale 1ns/1ps
module otp_prom_bench;
  localparam int AW    = 13;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, init, ce_n, oe_n, pe_n;
  logic [AW-1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic drive_en, dvalid, prog_done, clr_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  otp_prom u_otp_prom (
    .clk(clk), .rst(rst), .init(init), .ce_n(ce_n), .oe_n(oe_n),
    .pe_n(pe_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .drive_en(drive_en), .dvalid(dvalid), .prog_done(prog_done),
    .clr_busy(clr_busy)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  function automatic logic [7:0] pat1(input int a);
    return 8'((a * 37 + (a >> 8)) & 8'hFF) & 8'hB6;
  endfunction

  function automatic logic [7:0] pat2(input int a);
    return 8'((a * 11 + 3) & 8'hFF);
  endfunction

  // full access: capture, scramble addr (R2), sample, deselect (R3)
  task automatic do_read(input int a, input string req, input bit full);
    ce_n = 1'b0; oe_n = 1'b0; addr = AW'(a);
    tick();
    addr = ~AW'(a);
    tick();
    check(req, "rdata", rdata, model[a]);
    if (full) begin
      check("R4", "drive_en", drive_en, 1);
      check("R4", "dvalid", dvalid, 1);
    end
    ce_n = 1'b1;
    tick();
    if (full) begin
      check("R3", "drive_en off", drive_en, 0);
      check("R3", "rdata off", rdata, 0);
    end
  endtask

  task automatic do_prog(input int a, input logic [7:0] d, input bit strobe,
                         input bit sel, input bit expect_ok);
    ce_n = !sel; addr = AW'(a);
    tick();
    pe_n = !strobe; wdata = d; addr = ~AW'(a);
    tick();
    check("R8", "prog_done pulse", prog_done, int'(expect_ok));
    if (expect_ok) model[a] = model[a] | d;
    pe_n = 1'b1; wdata = 8'h00;
    tick();
    check("R8", "prog_done drop", prog_done, 0);
    ce_n = 1'b1;
    tick();
  endtask

  initial begin
    rst = 1'b1; init = 1'b0; ce_n = 1'b1; oe_n = 1'b1; pe_n = 1'b1;
    addr = '0; wdata = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) tick();
    check("R3", "reset drive_en", drive_en, 0);
    check("R8", "reset prog_done", prog_done, 0);
    check("R1", "reset clr_busy", clr_busy, 1);
    rst = 1'b0;
    repeat (DEPTH - 1) tick();
    check("R1", "busy at last sweep edge", clr_busy, 1);
    tick();
    check("R1", "busy after sweep", clr_busy, 0);

    // R1: every word zero after reset sweep
    for (int a = 0; a < DEPTH; a++) do_read(a, "R1", a % 512 == 0);

    // R6: first pattern everywhere
    for (int a = 0; a < DEPTH; a++) do_prog(a, pat1(a), 1'b1, 1'b1, 1'b1);
    // R6: overlapping second pattern, ones never cleared
    for (int a = 0; a < DEPTH; a += 3) do_prog(a, pat2(a), 1'b1, 1'b1, 1'b1);
    // R7: strobe idle or chip not selected: ignored
    for (int a = 1; a < DEPTH; a += 7)
      do_prog(a, 8'hFF, a % 2 == 0, a % 2 != 0, 1'b0);

    // R6 / R7: full compare against OR model
    for (int a = 0; a < DEPTH; a++) do_read(a, "R6", a % 256 == 0);

    // R5: output enable off keeps access selected
    for (int a = 5; a < DEPTH; a += 1021) begin
      ce_n = 1'b0; oe_n = 1'b1; addr = AW'(a);
      tick();
      addr = '0;
      tick();
      check("R5", "dvalid oe off", dvalid, 1);
      check("R5", "drive_en oe off", drive_en, 0);
      check("R5", "rdata oe off", rdata, 0);
      oe_n = 1'b0;
      tick();
      check("R5", "drive_en oe on", drive_en, 1);
      check("R5", "rdata oe on", rdata, model[a]);
      // R3: deselect with oe low
      ce_n = 1'b1;
      tick();
      check("R3", "dvalid deselect", dvalid, 0);
      check("R3", "rdata deselect", rdata, 0);
    end

    // R1 / R9: init sweep, accesses during it are inert
    init = 1'b1;
    tick();
    init = 1'b0;
    check("R1", "init busy", clr_busy, 1);
    ce_n = 1'b0; oe_n = 1'b0; addr = AW'(3);
    tick();
    tick();
    check("R9", "drive_en busy", drive_en, 0);
    check("R9", "dvalid busy", dvalid, 0);
    pe_n = 1'b0; wdata = 8'hFF;
    tick();
    check("R9", "prog_done busy", prog_done, 0);
    pe_n = 1'b1; wdata = 8'h00; ce_n = 1'b1;
    for (int i = 0; i < DEPTH && clr_busy; i++) tick();
    check("R1", "init sweep ends", clr_busy, 0);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    for (int a = 0; a < DEPTH; a += 5) do_read(a, "R1", a % 1000 == 0);
    do_read(3, "R9", 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule